// File: doc/BRIEF.md
# SSI Absolute Encoder Slave Transmitter

This block is the encoder side of a synchronous serial position link. A master drives a clock line that rests high; the block answers on a single data line. The first falling clock edge of a burst, seen while the line is idle, freezes the parallel position word and the status bits into a frame register. Each following rising edge puts out one frame bit. The position goes first, from its most significant bit down, and the status bits follow it.

After the last frame bit, a retriggerable timer in the system clock domain takes over. The final bit stays on the line for a short hold window. The line is then driven low until the timer has run out with no clock edge arriving, and after that it returns to its high idle level.

If the master keeps clocking instead of pausing, the bits that have already been sent have been rotated back into the frame register. The same frozen value therefore repeats, starting again from its most significant bit, for as long as the clock runs. The external clock is brought in through a synchroniser, so every visible data change lags the clock transition by a fixed number of system cycles.

Top module: `ssi_enc_tx`

## Requirements
- R1: After reset the data output is high and the block is idle, waiting for a burst.
- R2: The data output changes on the third system clock rising edge after a change of the SSI clock is first sampled. The first rising SSI clock edge of a frame presents the most significant position bit, and each later rising edge presents the next lower bit.
- R3: The position and status inputs are captured on the first falling SSI clock edge seen while idle. Changes to those inputs after that edge have no effect on the frame being sent. Between that falling edge and the first rising edge the data output stays high.
- R4: After the last frame bit has been presented, that bit remains on the data output for HOLD_CYC system cycles counted from the last SSI clock edge. The data output is then low while the timer is running.
- R5: Every SSI clock edge while the block is busy reloads the timer. The data output returns high MONO_CYC system cycles after the last edge if no further edge arrives. An interrupted frame is abandoned the same way, and the next burst starts a fresh frame from the most significant bit.
- R6: Rising edges beyond the frame length repeat the frozen frame from its most significant bit, with no new capture, for as many frames as are clocked.
- R7: A falling SSI clock edge that arrives while the timer is still running starts no new capture. The following rising edges continue the rotation of the old frame.
- R8: The STAT_W status bits follow the position LSB in the order status_i[0] first, then status_i[1], and so on. Frame length is POS_W+STAT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ssi_clk_i | input | 1 | Master shift clock, asynchronous, idles high |
| pos_i | input | POS_W | Absolute position word from the sensor side |
| status_i | input | STAT_W | Status bits, bit 0 is the alarm and is sent first |
| ssi_data_o | output | 1 | Serial data line toward the master |

## Verification
A corrupted frame register or bit counter shows up directly on the data line as a wrong bit. The bit is sampled on the edge that carries it, three system cycles after the SSI clock transition, so the error is visible within one SSI bit period. A fault in the retriggerable timer shows as a low gap that ends early or late, or as a missing low gap, and the cycle-level reference exposes it on the first system cycle where the line level differs. A wrong capture decision, such as recapturing during the low gap or failing to wrap in ring readout, shows as a whole frame carrying the wrong value. The bench reassembles each frame it receives and compares it with the value it expected to be frozen.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } sclk_edge_t;
endpackage

// File: rtl/ssi_tx_sync.sv
module ssi_tx_sync
   import ssi_tx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_async,
   output sclk_edge_t edge_o
);
   localparam int PW = SYNC_STAGES + 1;

   logic [PW-1:0] pipe;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[PW-2:0], sclk_async};
   end

   assign edge_o.rise = pipe[PW-2] & ~pipe[PW-1];
   assign edge_o.fall = ~pipe[PW-2] & pipe[PW-1];
endmodule

// File: rtl/ssi_tx_monoflop.sv
module ssi_tx_monoflop #(
   parameter int MONO_CYC = 3000,
   parameter int HOLD_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic retrig_i,
   output logic running_o,
   output logic hold_over_o
);
   localparam int CW = $clog2(MONO_CYC + 1);
   localparam logic [CW-1:0] RELOAD = CW'(MONO_CYC);
   localparam logic [CW-1:0] LIMIT  = CW'(MONO_CYC - HOLD_CYC);

   logic [CW-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n)             count <= '0;
      else if (retrig_i)      count <= RELOAD;
      else if (count != '0)   count <= count - 1'b1;
   end

   assign running_o   = (count != '0);
   assign hold_over_o = (count < LIMIT);

   assert_count_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= RELOAD);
   assert_expire_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_o && $past(running_o)) |-> !$past(retrig_i));
endmodule

// File: rtl/ssi_tx_shifter.sv
module ssi_tx_shifter
   import ssi_tx_pkg::*;
#(
   parameter int POS_W  = 24,
   parameter int STAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sclk_edge_t        edge_i,
   input  logic              running_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic              bit_o,
   output logic              started_o,
   output logic              done_o
);
   localparam int FW = POS_W + STAT_W;
   localparam int BW = $clog2(FW + 1);
   localparam logic [BW-1:0] LAST = BW'(FW);
   localparam logic [BW-1:0] ONE  = BW'(1);

   logic [FW-1:0]     frame;
   logic [FW-1:0]     shreg;
   logic [BW-1:0]     bitcnt;
   logic [STAT_W-1:0] stat_tail;

   genvar g;
   generate
      for (g = 0; g < STAT_W; g++) begin : g_stat_order
         assign stat_tail[STAT_W-1-g] = stat_i[g];
      end
   endgenerate

   assign frame = {pos_i, stat_tail};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '0;
         bitcnt <= '0;
         bit_o  <= 1'b1;
      end else if (!running_i && edge_i.fall) begin
         shreg  <= frame;
         bitcnt <= '0;
      end else if (running_i && edge_i.rise) begin
         bit_o  <= shreg[FW-1];
         shreg  <= {shreg[FW-2:0], shreg[FW-1]};
         bitcnt <= (bitcnt == LAST) ? ONE : bitcnt + 1'b1;
      end
   end

   assign started_o = (bitcnt != '0);
   assign done_o    = (bitcnt == LAST);

   assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= LAST);
   assert_ring_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i.rise && running_i && done_o) |=> (bitcnt == ONE));
   assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_i.rise && !edge_i.fall) |=> $stable(shreg));
   assert_no_recapture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running_i && edge_i.fall) |=> $stable(shreg));
endmodule

// File: rtl/ssi_enc_tx.sv
module ssi_enc_tx
   import ssi_tx_pkg::*;
#(
   parameter int POS_W       = 24,
   parameter int STAT_W      = 2,
   parameter int MONO_CYC    = 3000,
   parameter int HOLD_CYC    = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ssi_clk_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [STAT_W-1:0] status_i,
   output logic              ssi_data_o
);
   sclk_edge_t sedge;
   logic       running, hold_over, cur_bit, started, done, retrig;

   initial begin
      assert (POS_W >= 1) else $error("POS_W must be at least 1");
      assert (STAT_W >= 1) else $error("STAT_W must be at least 1");
      assert (HOLD_CYC >= 1 && HOLD_CYC < MONO_CYC)
         else $error("HOLD_CYC must lie between 1 and MONO_CYC-1");
   end

   ssi_tx_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .sclk_async(ssi_clk_i), .edge_o(sedge));

   assign retrig = sedge.fall | (sedge.rise & running);

   ssi_tx_monoflop #(.MONO_CYC(MONO_CYC), .HOLD_CYC(HOLD_CYC)) mono_i (
      .clk(clk), .rst_n(rst_n), .retrig_i(retrig),
      .running_o(running), .hold_over_o(hold_over));

   ssi_tx_shifter #(.POS_W(POS_W), .STAT_W(STAT_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .edge_i(sedge), .running_i(running),
      .pos_i(pos_i), .stat_i(status_i),
      .bit_o(cur_bit), .started_o(started), .done_o(done));

   always_comb begin
      if (!running || !started) ssi_data_o = 1'b1;
      else if (done && hold_over) ssi_data_o = 1'b0;
      else ssi_data_o = cur_bit;
   end

   assert_low_needs_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ssi_data_o |-> running);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> ssi_data_o);
endmodule

// File: tb/ssi_enc_tx_tb_top.sv
`timescale 1ns/1ps
module ssi_enc_tx_tb_top;
   localparam int POS_W = 11;
   localparam int STAT_W = 2;
   localparam int MONO = 200;
   localparam int HOLD = 12;
   localparam int HALF = 10;
   localparam int FW = POS_W + STAT_W;

   logic clk = 0;
   logic rst_n = 0;
   logic ssi_clk = 1;
   logic [POS_W-1:0] pos = '0;
   logic [STAT_W-1:0] stat = '0;
   logic ssi_data;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ssi_enc_tx #(.POS_W(POS_W), .STAT_W(STAT_W), .MONO_CYC(MONO), .HOLD_CYC(HOLD))
   dut_i (.clk(clk), .rst_n(rst_n), .ssi_clk_i(ssi_clk), .pos_i(pos),
          .status_i(stat), .ssi_data_o(ssi_data));

   // behavioural reference
   bit h0 = 1, h1 = 1, h2 = 1, h3 = 1;
   int cnt = 0;
   int bits = 0;
   bit cur = 1;
   bit expd = 1;
   bit q[$];
   string phase = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         h0 = 1; h1 = 1; h2 = 1; h3 = 1;
         cnt = 0; bits = 0; cur = 1; q.delete();
      end else begin
         bit rise, fall;
         h3 = h2; h2 = h1; h1 = h0; h0 = ssi_clk;
         rise = h2 && !h3;
         fall = !h2 && h3;
         if (cnt == 0) begin
            if (fall) begin
               q.delete();
               for (int i = POS_W - 1; i >= 0; i--) q.push_back(pos[i]);
               for (int g = 0; g < STAT_W; g++) q.push_back(stat[g]);
               bits = 0;
               cnt = MONO;
            end
         end else if (rise || fall) begin
            if (rise) begin
               cur = q[0];
               q.push_back(q.pop_front());
               bits = (bits == FW) ? 1 : bits + 1;
            end
            cnt = MONO;
         end else begin
            cnt = cnt - 1;
         end
      end
      if (cnt == 0) begin expd = 1; phase = "R5"; end
      else if (bits == 0) begin expd = 1; phase = "R3"; end
      else if (bits == FW && cnt < MONO - HOLD) begin expd = 0; phase = "R4"; end
      else begin expd = cur; phase = "R2"; end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         total++;
         if (ssi_data !== expd) begin
            bad++;
            $display("FAIL %s per-cycle data actual=%0b expected=%0b at %0t",
                     phase, ssi_data, expd, $time);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic burst(input int nrise, input bit flip, output logic [63:0] got);
      got = '0;
      ssi_clk = 0;
      wait_cyc(HALF);
      for (int i = 0; i < nrise; i++) begin
         ssi_clk = 1;
         wait_cyc(5);
         got = {got[62:0], ssi_data};
         if (flip && i == 0) begin
            pos = ~pos;
            stat = ~stat;
         end
         wait_cyc(HALF - 5);
         if (i != nrise - 1) begin
            ssi_clk = 0;
            wait_cyc(HALF);
         end
      end
   endtask

   function automatic logic [63:0] frame_of(input logic [POS_W-1:0] p,
                                            input logic [STAT_W-1:0] s);
      logic [63:0] f;
      f = 64'(p);
      for (int g = 0; g < STAT_W; g++) f = {f[62:0], s[g]};
      return f;
   endfunction

   initial begin
      logic [63:0] got, ea, eb;
      wait_cyc(5);
      rst_n = 1;
      wait_cyc(1);
      chk(ssi_data == 1'b1, "R1 reset level", 64'(ssi_data), 64'd1);
      wait_cyc(10);

      // plain frame, inputs toggled after capture
      pos = 11'h5A3; stat = 2'b01;
      ea = frame_of(pos, stat);
      burst(FW, 1'b1, got);
      chk(got[FW-1:0] == ea[FW-1:0], "R2 MSB-first frame", got, ea);
      chk(got[FW-1:0] == ea[FW-1:0], "R3 frozen capture", got, ea);
      chk(got[1:0] == 2'b10, "R8 status order", 64'(got[1:0]), 64'd2);
      wait_cyc(10);
      chk(ssi_data == 1'b0, "R4 low gap", 64'(ssi_data), 64'd0);
      wait_cyc(150);
      chk(ssi_data == 1'b0, "R5 still low before expiry", 64'(ssi_data), 64'd0);
      wait_cyc(60);
      chk(ssi_data == 1'b1, "R5 high after expiry", 64'(ssi_data), 64'd1);

      // ring readout
      pos = 11'h0F1; stat = 2'b10;
      ea = frame_of(pos, stat);
      burst(2 * FW, 1'b0, got);
      chk(got[2*FW-1:0] == {ea[FW-1:0], ea[FW-1:0]}, "R6 ring repeat",
          got, {ea[FW-1:0], ea[FW-1:0]});
      wait_cyc(250);

      // restart inside low gap keeps old frame
      pos = 11'h3C7; stat = 2'b11;
      ea = frame_of(pos, stat);
      burst(FW, 1'b0, got);
      chk(got[FW-1:0] == ea[FW-1:0], "R2 frame all-ones status", got, ea);
      wait_cyc(40);
      chk(ssi_data == 1'b0, "R4 gap before restart", 64'(ssi_data), 64'd0);
      pos = 11'h111; stat = 2'b00;
      eb = frame_of(pos, stat);
      burst(FW, 1'b0, got);
      chk(got[FW-1:0] == ea[FW-1:0], "R7 no recapture in gap", got, ea);
      wait_cyc(250);
      burst(FW, 1'b0, got);
      chk(got[FW-1:0] == eb[FW-1:0], "R3 fresh capture after idle", got, eb);
      wait_cyc(250);

      // interrupted frame
      burst(5, 1'b0, got);
      chk(got[4:0] == eb[FW-1:FW-5], "R2 partial frame", got, 64'(eb[FW-1:FW-5]));
      wait_cyc(250);
      chk(ssi_data == 1'b1, "R5 idle after abort", 64'(ssi_data), 64'd1);
      pos = 11'h7FE; stat = 2'b01;
      ea = frame_of(pos, stat);
      burst(FW, 1'b0, got);
      chk(got[FW-1:0] == ea[FW-1:0], "R5 restart from MSB", got, ea);
      wait_cyc(250);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         bad++;
         total++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule